// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block passes an 18-bit word between two buses, called A and B, with a separate path for each direction. Each path holds one storage register that works either as a transparent latch or as an edge-triggered register, chosen cycle by cycle by a pass input. In register mode a strobe input is sampled on the system clock, and a low-to-high change of the strobe loads the word. An active-low clock enable can block that load. An active-low output enable switches the path's drivers on and off.

Both bus sides are modelled as plain vectors: an input vector, an output vector and a per-bit output-enable vector. A pad ring or the surrounding logic turns these into real tri-state pins. The two paths share only the system clock and reset, so traffic in one direction has no effect on the other.

Top module: `bidir_store_xcvr`

## Requirements
- R1: Both paths are 18 bits wide and non-inverting. While `ab_pass` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R2: While `ab_pass` is 0 and no qualifying strobe edge is seen at a clock edge, `b_out` keeps the word stored at the earlier edges.
- R3: A qualifying edge needs all of the following at a rising `clk`: `ab_pass` is 0, `ab_strobe` is sampled 1, it was sampled 0 at the previous edge, and `ab_ce_n` is 0. On such an edge, `a_in` is stored and shows on `b_out` after that edge.
- R4: The clock enable is active low. While `ab_ce_n` is 1, a rising strobe is ignored and `b_out` holds its value.
- R5: While `ab_pass` is 1, the storage loads `a_in` at every clock edge. After `ab_pass` drops to 0, `b_out` therefore shows the `a_in` value from the last edge at which `ab_pass` was 1.
- R6: The output enable is active low. `b_oe` is all ones while `ab_oe_n` is 0 and all zeros while it is 1. `b_out` carries the stored or passed word in both cases.
- R7: The output enable never gates the storage. A word captured while `b_oe` is all zeros appears on `b_out` once the drivers are enabled.
- R8: While `rst_n` is 0, `a_oe` and `b_oe` are all zeros and both stores are cleared to zero. Reset also records each strobe as previously high, so a strobe held at 1 when reset ends is not an edge.
- R9: The B-to-A path behaves like the A-to-B path, using `ba_pass`, `ba_strobe`, `ba_ce_n` and `ba_oe_n`, with `b_in` as its source and `a_out`/`a_oe` as its outputs. The two paths are fully independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word received from the A bus |
| a_out | output | 18 | Word to drive onto the A bus |
| a_oe | output | 18 | Per-bit drive enable for the A bus |
| b_in | input | 18 | Word received from the B bus |
| b_out | output | 18 | Word to drive onto the B bus |
| b_oe | output | 18 | Per-bit drive enable for the B bus |
| ab_pass | input | 1 | A-to-B transparent select (1 = pass through) |
| ab_strobe | input | 1 | A-to-B load strobe, rising edge loads |
| ab_ce_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe_n | input | 1 | B-side driver enable, active low |
| ba_pass | input | 1 | B-to-A transparent select |
| ba_strobe | input | 1 | B-to-A load strobe |
| ba_ce_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | A-side driver enable, active low |

## Verification
Edge detection works on the sampled strobe, so the hardest case to reach is a rising strobe that lines up with pass low, the enable low and fresh data. The case must also be told apart from a strobe that was already high. The stimulus therefore holds the strobe low for one cycle before raising it. It repeats the same pattern with the enable high, and again with the drivers off. Long random runs bias the strobe to toggle often and the pass input to stay low most of the time. They also drop reset mid-run while a strobe is high, to exercise the history set by reset.

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_ce_n,
  input  logic         ab_oe_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_ce_n,
  input  logic         ba_oe_n
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_sq, ba_sq;
  logic         armed;

  wire ab_load = ab_pass || (ab_strobe && !ab_sq && !ab_ce_n);
  wire ba_load = ba_pass || (ba_strobe && !ba_sq && !ba_ce_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q  <= '0;
      ba_q  <= '0;
      ab_sq <= 1'b1;
      ba_sq <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (ab_load) ab_q <= a_in;
      if (ba_load) ba_q <= b_in;
      ab_sq <= ab_strobe;
      ba_sq <= ba_strobe;
      armed <= 1'b1;
    end
  end

  assign b_out = ab_pass ? a_in : ab_q;
  assign a_out = ba_pass ? b_in : ba_q;
  assign b_oe  = {W{rst_n && !ab_oe_n}};
  assign a_oe  = {W{rst_n && !ba_oe_n}};

  AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass |-> b_out == a_in); // R1
  AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass |-> a_out == b_in); // R9
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ab_pass && !(ab_strobe && !ab_sq) |=> (ab_pass || b_out == $past(b_out))); // R2
  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ab_pass && !ab_ce_n && ab_strobe && !ab_sq |=> (ab_pass || b_out == $past(a_in))); // R3
  AST_AB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ab_pass && ab_ce_n |=> (ab_pass || b_out == $past(b_out))); // R4
  AST_BA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ba_pass && ba_ce_n |=> (ba_pass || a_out == $past(a_out))); // R9
  AST_AB_PASS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ab_pass |=> (ab_pass || b_out == $past(a_in))); // R5
  AST_OE_ONEHOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe == '0 || b_oe == '1) && (a_oe == '0 || a_oe == '1)); // R6

  always_comb begin
    if (!rst_n) AST_RESET_HIZ: assert (a_oe == '0 && b_oe == '0); // R8
  end

endmodule

// File: tb/bidir_store_xcvr_test.sv
module bidir_store_xcvr_test;
  localparam int W = 18;
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
  logic ab_pass, ab_strobe, ab_ce_n, ab_oe_n;
  logic ba_pass, ba_strobe, ba_ce_n, ba_oe_n;

  int compared = 0;
  int mismatched = 0;
  string ph = "R8";
  bit done = 0;

  logic [W-1:0] m_ab, m_ba;
  logic m_absq, m_basq;

  always #(PERIOD/2) clk = ~clk;

  bidir_store_xcvr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n)
  );

  task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", ph, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] eb, ea, eboe, eaoe;
    eb = ab_pass ? a_in : m_ab;
    ea = ba_pass ? b_in : m_ba;
    eboe = (rst_n && !ab_oe_n) ? '1 : '0;
    eaoe = (rst_n && !ba_oe_n) ? '1 : '0;
    cmp("b_out", b_out, eb);
    cmp("a_out", a_out, ea);
    cmp("b_oe", b_oe, eboe);
    cmp("a_oe", a_oe, eaoe);
  endtask

  // one cycle: drive at negedge, compare, then advance model after posedge
  task automatic cyc();
    if (!rst_n) begin m_ab = '0; m_ba = '0; m_absq = 1'b1; m_basq = 1'b1; end
    #1;
    check_all();
    @(posedge clk);
    if (rst_n) begin
      if (ab_pass || (ab_strobe && !m_absq && !ab_ce_n)) m_ab = a_in;
      if (ba_pass || (ba_strobe && !m_basq && !ba_ce_n)) m_ba = b_in;
      m_absq = ab_strobe;
      m_basq = ba_strobe;
    end
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_in = 18'h2A5A5; b_in = 18'h15A5A;
    ab_pass = 0; ab_strobe = 1; ab_ce_n = 0; ab_oe_n = 0;
    ba_pass = 0; ba_strobe = 1; ba_ce_n = 0; ba_oe_n = 0;
    m_ab = '0; m_ba = '0; m_absq = 1; m_basq = 1;
    @(negedge clk);
    ph = "R8"; cyc(); cyc();
    rst_n = 1; cyc();          // strobe held high: no edge after reset
    ab_strobe = 0; ba_strobe = 0; cyc();
    // R1 / R9 transparency
    ph = "R1"; ab_pass = 1; ba_pass = 1;
    for (int i = 0; i < 4; i++) begin a_in = $urandom; b_in = $urandom; cyc(); end
    // R5 exit of pass
    ph = "R5"; ab_pass = 0; ba_pass = 0; a_in = 18'h3FFFF; b_in = 18'h00001; cyc(); cyc();
    // R2 hold
    ph = "R2"; for (int i = 0; i < 3; i++) begin a_in = $urandom; b_in = $urandom; cyc(); end
    // R3 capture
    ph = "R3"; a_in = 18'h12345; b_in = 18'h2BCDE; ab_strobe = 1; ba_strobe = 1; cyc();
    a_in = 18'h0F0F0; b_in = 18'h30303; cyc();   // strobe still high: hold
    ab_strobe = 0; ba_strobe = 0; cyc();
    // R4 gated
    ph = "R4"; ab_ce_n = 1; ba_ce_n = 1; a_in = 18'h11111; b_in = 18'h22222;
    ab_strobe = 1; ba_strobe = 1; cyc(); ab_strobe = 0; ba_strobe = 0; cyc();
    ab_ce_n = 0; ba_ce_n = 0;
    // R6 / R7 drivers off, capture, then enable
    ph = "R6"; ab_oe_n = 1; ba_oe_n = 1; cyc();
    ph = "R7"; a_in = 18'h2468A; b_in = 18'h13579; ab_strobe = 1; ba_strobe = 1; cyc();
    ab_strobe = 0; ba_strobe = 0; a_in = 0; b_in = 0; cyc();
    ab_oe_n = 0; ba_oe_n = 0; cyc();
    // R9 independence: only A-to-B active
    ph = "R9"; ba_ce_n = 1;
    for (int i = 0; i < 6; i++) begin a_in = $urandom; b_in = $urandom; ab_strobe = i[0]; cyc(); end
    ba_ce_n = 0; ab_strobe = 0;
    // random mix with mid-run resets
    ph = "R3";
    for (int i = 0; i < 3000; i++) begin
      a_in = $urandom; b_in = $urandom;
      ab_pass = ($urandom % 6) == 0; ba_pass = ($urandom % 6) == 0;
      ab_strobe = $urandom; ba_strobe = $urandom;
      ab_ce_n = ($urandom % 4) == 0; ba_ce_n = ($urandom % 4) == 0;
      ab_oe_n = $urandom; ba_oe_n = $urandom;
      rst_n = ($urandom % 200) != 0;
      ph = rst_n ? "R2" : "R8";
      cyc();
    end
    rst_n = 1; cyc();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule